// File: doc/BRIEF.md
# Soft-Start Ramp Sequencer

This block produces the digital soft-start reference for a switching regulator controller. It counts PWM switching cycles instead of charging a capacitor. A DAC outside the block turns the count into the reference that feeds the error amplifier. Besides the ramp code, the block drives three milestone flags:

- one that lets the low-side switch run in full synchronous rectification,
- one that marks the point where the output has reached regulation,
- one that arms the fault protections once the ramp is complete.

The sequencer arms when the bias supply reports good and enable is high. On the arming cycle it samples the feedback-short detector. If the feedback node reads as shorted, the ramp stays at zero and the regulator does not start. If the node is clear, each PWM tick adds one step to the ramp. The ramp saturates at full scale, and the flags stay set after that. When bias-good or enable goes low, the ramp discharges to zero and the sequence starts again from the beginning.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `ramp_code` is 0 and `sync_en`, `reg_reached` and `fault_en` are all 0.
- R2: The sequencer arms on a rising clock edge at which `bias_ok` and `enable` are both 1. A tick sampled on that arming edge is not counted. Counting begins at the next edge.
- R3: While ramping, each edge with `tick`=1 raises `ramp_code` by exactly one. An edge with `tick`=0 leaves it unchanged.
- R4: If `fb_short` is 1 on the arming edge, the sequencer locks out. `ramp_code` and all flags stay 0 regardless of `tick` or `fb_short`, until `bias_ok` or `enable` goes low. A `fb_short` pulse after arming has no effect on the ramp.
- R5: `sync_en` is 1 exactly when `ramp_code` >= 3040, which is 95 % of the reference point.
- R6: `reg_reached` is 1 exactly when `ramp_code` >= 3200, the regulation reference point.
- R7: `fault_en` is 1 exactly when `ramp_code` >= 4000, the full-scale point.
- R8: `ramp_code` never exceeds 4000. Further ticks hold it at 4000, with all three flags held at 1.
- R9: An edge with `bias_ok`=0 or `enable`=0 forces `ramp_code` to 0 and all flags to 0 after that edge. A later edge with both inputs high re-arms the sequencer, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per PWM switching cycle |
| bias_ok | input | 1 | Bias supply above its undervoltage threshold |
| enable | input | 1 | Regulator enable request |
| fb_short | input | 1 | Feedback node detected as shorted to ground |
| ramp_code | output | 12 | Soft-start reference code, 0 to 4000 |
| sync_en | output | 1 | Permits full synchronous rectification |
| reg_reached | output | 1 | Ramp has reached the regulation reference |
| fault_en | output | 1 | Ramp complete; fault protections armed |

## Verification
Every result of this block is due on the first sample after the edge that consumes the stimulus:

- the arming decision,
- each counted tick,
- the discharge caused by a drop of bias or enable,
- each flag, which decodes the new count within that same cycle.

The bench drives inputs on the falling edge, and its reference model advances on the rising edge from the same sampled inputs. It compares all four outputs at the next falling edge. The directed part then stops the ramp at counts 3039, 3040, 3199, 3200, 3999 and 4000 to check the exact tick on which each flag rises.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

   typedef enum logic [1:0] {
      SS_IDLE   = 2'd0,
      SS_RAMP   = 2'd1,
      SS_LOCKED = 2'd2
   } ss_state_e;

   localparam int unsigned SS_NUM_MARKS = 3;

   localparam int unsigned SS_MARK_SYNC  = 0;
   localparam int unsigned SS_MARK_REG   = 1;
   localparam int unsigned SS_MARK_FAULT = 2;

endpackage

// File: rtl/ss_arm_fsm.sv
module ss_arm_fsm
   import softstart_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fb_short,
   output logic ramping
);

   ss_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!run) begin
         state_d = SS_IDLE;
      end else begin
         case (state_q)
            SS_IDLE:   state_d = fb_short ? SS_LOCKED : SS_RAMP;
            SS_RAMP:   state_d = SS_RAMP;
            SS_LOCKED: state_d = SS_LOCKED;
            default:   state_d = SS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SS_IDLE;
      else        state_q <= state_d;
   end

   assign ramping = (state_q == SS_RAMP);

   // R4
   short_blocks_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SS_IDLE && run && fb_short) |=> (state_q == SS_LOCKED));

   // R4
   lock_is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SS_LOCKED && run) |=> (state_q == SS_LOCKED));

   // R9
   drop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (state_q == SS_IDLE));

endmodule

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter #(
   parameter int unsigned FULL_TICKS = 4000,
   parameter int unsigned CW         = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] FULL_CODE = CW'(FULL_TICKS);

   logic [CW-1:0] count_q;
   logic          at_full;

   assign at_full = (count_q == FULL_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count_q <= '0;
      else if (clear)             count_q <= '0;
      else if (step && !at_full)  count_q <= count_q + 1'b1;
   end

   assign count = count_q;

   // R8
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CODE);

   // R3
   step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && step && count_q < FULL_CODE) |=> (count_q == $past(count_q) + 1'b1));

   // R3
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step) |=> $stable(count_q));

   // R9
   clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count_q == '0));

endmodule

// File: rtl/ss_milestones.sv
module ss_milestones
   import softstart_pkg::*;
#(
   parameter int unsigned SYNC_TICKS = 3040,
   parameter int unsigned REF_TICKS  = 3200,
   parameter int unsigned FULL_TICKS = 4000,
   parameter int unsigned CW         = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CW-1:0]           count,
   output logic [SS_NUM_MARKS-1:0] marks
);

   localparam logic [SS_NUM_MARKS-1:0][CW-1:0] MARK_AT = {
      CW'(FULL_TICKS), CW'(REF_TICKS), CW'(SYNC_TICKS)
   };

   for (genvar i = 0; i < SS_NUM_MARKS; i++) begin : g_mark
      assign marks[i] = (count >= MARK_AT[i]);
   end

   // R7
   mark_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      marks[SS_MARK_FAULT] |-> (marks[SS_MARK_REG] && marks[SS_MARK_SYNC]));

   // R9
   mark_falls_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(marks[SS_MARK_SYNC]) |-> (count == '0));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import softstart_pkg::*;
#(
   parameter int unsigned SYNC_TICKS = 3040,
   parameter int unsigned REF_TICKS  = 3200,
   parameter int unsigned FULL_TICKS = 4000,
   localparam int unsigned CW        = $clog2(FULL_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bias_ok,
   input  logic          enable,
   input  logic          fb_short,
   output logic [CW-1:0] ramp_code,
   output logic          sync_en,
   output logic          reg_reached,
   output logic          fault_en
);

   if (!(SYNC_TICKS > 0 && SYNC_TICKS < REF_TICKS && REF_TICKS < FULL_TICKS))
   begin : g_bad_cfg
      $error("softstart_seq: milestones must satisfy 0 < SYNC < REF < FULL");
   end

   logic                    run;
   logic                    ramping;
   logic [CW-1:0]           count;
   logic [SS_NUM_MARKS-1:0] marks;

   assign run = bias_ok & enable;

   ss_arm_fsm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .fb_short (fb_short),
      .ramping  (ramping)
   );

   ss_ramp_counter #(
      .FULL_TICKS (FULL_TICKS),
      .CW         (CW)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!run),
      .step  (ramping & tick),
      .count (count)
   );

   ss_milestones #(
      .SYNC_TICKS (SYNC_TICKS),
      .REF_TICKS  (REF_TICKS),
      .FULL_TICKS (FULL_TICKS),
      .CW         (CW)
   ) u_marks (
      .clk   (clk),
      .rst_n (rst_n),
      .count (count),
      .marks (marks)
   );

   assign ramp_code   = count;
   assign sync_en     = marks[SS_MARK_SYNC];
   assign reg_reached = marks[SS_MARK_REG];
   assign fault_en    = marks[SS_MARK_FAULT];

   // R9
   discharge_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (ramp_code == '0 && !sync_en && !fault_en));

   // R4
   no_ramp_without_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_code != '0) |-> $past(run));

endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC_T = 3040;
   localparam int REF_T  = 3200;
   localparam int FULL_T = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bias_ok = 1'b0;
   logic        enable = 1'b0;
   logic        fb_short = 1'b0;
   logic [11:0] ramp_code;
   logic        sync_en, reg_reached, fault_en;

   int checks = 0;
   int failures = 0;

   // reference model state: 0 idle, 1 ramp, 2 locked
   int m_state = 0;
   int m_cnt = 0;

   softstart_seq dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bias_ok(bias_ok),
      .enable(enable), .fb_short(fb_short), .ramp_code(ramp_code),
      .sync_en(sync_en), .reg_reached(reg_reached), .fault_en(fault_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0; m_cnt <= 0;
      end else if (!(bias_ok && enable)) begin
         m_state <= 0; m_cnt <= 0;
      end else begin
         case (m_state)
            0: m_state <= fb_short ? 2 : 1;
            1: if (tick && m_cnt < FULL_T) m_cnt <= m_cnt + 1;
            default: ;
         endcase
      end
   end

   function automatic bit exp_flag(int cnt, int thr);
      return cnt >= thr;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R3 ramp_code", int'(ramp_code), m_cnt);
      chk("R5 sync_en", int'(sync_en), int'(exp_flag(m_cnt, SYNC_T)));
      chk("R6 reg_reached", int'(reg_reached), int'(exp_flag(m_cnt, REF_T)));
      chk("R7 fault_en", int'(fault_en), int'(exp_flag(m_cnt, FULL_T)));
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_all();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 250000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 code in reset", int'(ramp_code), 0);
      chk("R1 flags in reset", int'({sync_en, reg_reached, fault_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 code after release", int'(ramp_code), 0);

      // R2: arm, arming tick not counted
      bias_ok = 1'b1; enable = 1'b1; tick = 1'b1;
      step(1);
      chk("R2 arming tick ignored", int'(ramp_code), 0);
      step(1);
      chk("R2 first counted tick", int'(ramp_code), 1);
      step(SYNC_T - 2);
      chk("R5 sync_en at 3039", int'(sync_en), 0);
      step(1);
      chk("R5 sync_en at 3040", int'(sync_en), 1);
      step(REF_T - SYNC_T - 1);
      chk("R6 reg_reached at 3199", int'(reg_reached), 0);
      step(1);
      chk("R6 reg_reached at 3200", int'(reg_reached), 1);
      step(FULL_T - REF_T - 1);
      chk("R7 fault_en at 3999", int'(fault_en), 0);
      step(1);
      chk("R7 fault_en at 4000", int'(fault_en), 1);
      step(20);
      chk("R8 saturated code", int'(ramp_code), FULL_T);
      chk("R8 flags held", int'({sync_en, reg_reached, fault_en}), 7);

      // R9: enable drop discharges
      enable = 1'b0;
      step(1);
      chk("R9 enable drop code", int'(ramp_code), 0);
      chk("R9 enable drop flags", int'({sync_en, reg_reached, fault_en}), 0);

      // R4: shorted feedback locks out
      enable = 1'b1; fb_short = 1'b1;
      step(50);
      chk("R4 locked code", int'(ramp_code), 0);
      fb_short = 1'b0;
      step(50);
      chk("R4 still locked after short clears", int'(ramp_code), 0);

      // R9: bias drop and re-arm
      bias_ok = 1'b0;
      step(1);
      bias_ok = 1'b1;
      step(101);
      chk("R9 re-armed count", int'(ramp_code), 100);
      fb_short = 1'b1;
      step(10);
      chk("R4 short after arming ignored", int'(ramp_code), 110);
      fb_short = 1'b0; tick = 1'b0;
      step(10);
      chk("R3 no tick holds", int'(ramp_code), 110);

      // mid-ramp bias drop
      tick = 1'b1;
      step(200);
      bias_ok = 1'b0;
      step(1);
      chk("R9 mid-ramp bias drop", int'(ramp_code), 0);
      bias_ok = 1'b1;

      // constrained random phase
      for (int i = 0; i < 20000; i++) begin
         tick = ($urandom_range(3, 0) != 0);
         fb_short = ($urandom_range(7, 0) == 0);
         enable = ($urandom_range(2999, 0) != 0);
         bias_ok = ($urandom_range(4999, 0) != 0);
         step(1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule